// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the general registers and status registers of a 32-bit processor core with eight operating modes. Every register access names one of 16 architectural registers. The block translates that index through the current operating mode, which it keeps in the low five bits of its current status word. The same index can therefore reach a different physical register in a different mode. There are 33 physical general registers. Registers 0-7 and the program counter (register 15) are common to all modes. The fast-interrupt mode has its own registers 8-14. Each of the other five exception modes has its own stack pointer (register 13) and link register (register 14). User and System modes use the same physical registers.

The core reads through two combinational ports and writes through one port, and a separate branch-with-link input loads the link register. The current status word has its own read and write port. The saved status word has one too, and it exists only in the six exception modes. The exception-entry strobe performs three updates in a single clock edge: it saves the current status into the target mode's saved status, switches the mode, and writes the return address into the target mode's link register.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current status reads 0x0000_0013 (Supervisor mode, all other bits zero), every general register reads zero, and the saved status of every exception mode is zero.
- R2: The read ports are combinational. A write through the general write port is visible on both read ports from the next cycle. Registers 0-7 and 15 reach the same storage in every mode.
- R3: User (10000) and System (11111) modes share all registers. A value written to register 13 in User mode reads back unchanged in System mode, and it is not visible in any exception mode. Each exception mode has its own register 13 and register 14.
- R4: Fast-interrupt mode (10001) has private registers 8-12. All other modes share one copy of registers 8-12.
- R5: While the link strobe is high, its address is written into register 14 of the current mode. If the general write port targets register 14 in the same cycle, the link address wins.
- R6: Register 15 is word aligned. Bits [1:0] of its read value are always zero, whatever value is written.
- R7: A current-status write copies all 32 bits when bits [4:0] hold a legal mode: 10000, 10001, 10010 IRQ, 10011 Supervisor, 10110 Monitor, 10111 Abort, 11011 Undefined or 11111. With any other mode field, bits [31:5] are written and the mode is kept.
- R8: In an exception mode the saved-status port reads and writes that mode's own saved status. In User or System mode it reads the current status, and a write to it is ignored.
- R9: When the exception strobe is high and its target mode is one of the six exception modes, the old current status moves into the target's saved status. On the same edge the mode field becomes the target mode, bits [31:5] are kept, and the return address goes into the target's register 14. All other writes in that cycle are dropped.
- R10: An exception strobe whose target is User, System or an illegal code has no effect, and the other writes in that cycle proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index |
| wr_data_i | input | 32 | General write data |
| link_en_i | input | 1 | Branch-with-link strobe |
| link_addr_i | input | 32 | Return address for register 14 |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_wr_en_i | input | 1 | Saved status write enable |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of current mode (current status in User/System) |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 5 | Mode entered by the exception |
| exc_ret_addr_i | input | 32 | Return address stored on exception entry |

## Verification
The hardest case to reach is a value written in one bank that must stay out of sight in every other bank while the mode changes. The leak shows up only when a later read, in a different mode, lands on the same index. The stimulus therefore steps through the legal mode codes, mixed with illegal ones, and between those steps it fires exception strobes at every target. Every read port is compared against a model on every cycle, so any register that is aliased by mistake shows up on the first read that falls on the wrong bank. Directed sequences also cover the User/System stack-pointer handover, the fast-interrupt private registers, and an exception strobe that arrives in the same cycle as conflicting writes.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int NUM_ARCH = 16;
  localparam int NUM_PHYS = 33;
  localparam int NUM_SAVED = 6;
  localparam int BANK_W = 3;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_MON = 5'b10110;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  // bank 0 = user/system storage, 1..6 = exception banks
  localparam logic [BANK_W-1:0] BK_USR = 3'd0;
  localparam logic [BANK_W-1:0] BK_FIQ = 3'd1;
  localparam logic [BANK_W-1:0] BK_IRQ = 3'd2;
  localparam logic [BANK_W-1:0] BK_SVC = 3'd3;
  localparam logic [BANK_W-1:0] BK_ABT = 3'd4;
  localparam logic [BANK_W-1:0] BK_UND = 3'd5;
  localparam logic [BANK_W-1:0] BK_MON = 3'd6;

  function automatic logic mode_legal(logic [4:0] m);
    return m inside {MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
                     MODE_MON, MODE_ABT, MODE_UND, MODE_SYS};
  endfunction

  function automatic logic mode_is_exc(logic [4:0] m);
    return m inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_MON, MODE_ABT, MODE_UND};
  endfunction
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import banked_regfile_pkg::*;
(
  input  logic [4:0]        mode_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              is_exc_o,
  output logic              legal_o
);
  always_comb begin
    bank_o   = BK_USR;
    is_exc_o = 1'b1;
    legal_o  = 1'b1;
    unique case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      MODE_MON: bank_o = BK_MON;
      MODE_USR, MODE_SYS: is_exc_o = 1'b0;
      default: begin
        is_exc_o = 1'b0;
        legal_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
  import banked_regfile_pkg::*;
#(
  parameter int PW = $clog2(NUM_PHYS)
) (
  input  logic [3:0]        idx_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [PW-1:0]     phys_o
);
  localparam int FIQ_BASE  = NUM_ARCH;      // private 8..14 of fast-interrupt mode
  localparam int BANK_BASE = NUM_ARCH + 7;  // 13/14 pairs of remaining modes

  always_comb begin
    phys_o = PW'(idx_i);
    if (idx_i >= 4'd8 && idx_i <= 4'd14) begin
      if (bank_i == BK_FIQ)
        phys_o = PW'(FIQ_BASE + int'(idx_i) - 8);
      else if (idx_i >= 4'd13 && bank_i != BK_USR)
        phys_o = PW'(BANK_BASE + 2 * (int'(bank_i) - 2) + int'(idx_i) - 13);
    end
  end
endmodule

// File: rtl/rf_status.sv
module rf_status
  import banked_regfile_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] cur_bank_i,
  input  logic              cur_is_exc_i,
  input  logic              exc_take_i,
  input  logic [4:0]        exc_mode_i,
  input  logic [BANK_W-1:0] exc_bank_i,
  input  logic              cpsr_we_i,
  input  logic [DW-1:0]     cpsr_wd_i,
  input  logic              spsr_we_i,
  input  logic [DW-1:0]     spsr_wd_i,
  output logic [DW-1:0]     cpsr_o,
  output logic [DW-1:0]     spsr_o
);
  logic [DW-1:0] cpsr_q;
  logic [DW-1:0] saved_q [NUM_SAVED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q <= {{(DW-5){1'b0}}, MODE_SVC};
    end else if (exc_take_i) begin
      cpsr_q <= {cpsr_q[DW-1:5], exc_mode_i};
    end else if (cpsr_we_i) begin
      cpsr_q <= mode_legal(cpsr_wd_i[4:0]) ? cpsr_wd_i
                                           : {cpsr_wd_i[DW-1:5], cpsr_q[4:0]};
    end
  end

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(s + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        saved_q[s] <= '0;
      else if (exc_take_i) begin
        if (exc_bank_i == MY_BANK) saved_q[s] <= cpsr_q;
      end else if (spsr_we_i && cur_is_exc_i && cur_bank_i == MY_BANK)
        saved_q[s] <= spsr_wd_i;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = cur_is_exc_i ? saved_q[int'(cur_bank_i) - 1] : cpsr_q;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    rd_a_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [3:0]    rd_b_idx_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          link_en_i,
  input  logic [DW-1:0] link_addr_i,
  input  logic          cpsr_wr_en_i,
  input  logic [DW-1:0] cpsr_wr_data_i,
  output logic [DW-1:0] cpsr_o,
  input  logic          spsr_wr_en_i,
  input  logic [DW-1:0] spsr_wr_data_i,
  output logic [DW-1:0] spsr_o,
  input  logic          exc_en_i,
  input  logic [4:0]    exc_mode_i,
  input  logic [DW-1:0] exc_ret_addr_i
);
  localparam int PW     = $clog2(NUM_PHYS);
  localparam int NMAP   = 5;
  localparam int M_RDA  = 0;
  localparam int M_RDB  = 1;
  localparam int M_WR   = 2;
  localparam int M_LINK = 3;
  localparam int M_EXC  = 4;

  logic [BANK_W-1:0] cur_bank, exc_bank;
  logic              cur_is_exc, cur_legal, exc_is_exc, exc_legal, exc_take;
  logic [3:0]        map_idx  [NMAP];
  logic [BANK_W-1:0] map_bank [NMAP];
  logic [PW-1:0]     map_phys [NMAP];
  logic [DW-1:0]     gpr_q    [NUM_PHYS];
  logic [DW-1:0]     wr_data_al;

  rf_mode_decode u_cur_dec (
    .mode_i(cpsr_o[4:0]), .bank_o(cur_bank), .is_exc_o(cur_is_exc), .legal_o(cur_legal)
  );
  rf_mode_decode u_exc_dec (
    .mode_i(exc_mode_i), .bank_o(exc_bank), .is_exc_o(exc_is_exc), .legal_o(exc_legal)
  );

  assign exc_take = exc_en_i && exc_is_exc;

  assign map_idx[M_RDA]  = rd_a_idx_i;
  assign map_idx[M_RDB]  = rd_b_idx_i;
  assign map_idx[M_WR]   = wr_idx_i;
  assign map_idx[M_LINK] = 4'd14;
  assign map_idx[M_EXC]  = 4'd14;
  assign map_bank[M_RDA]  = cur_bank;
  assign map_bank[M_RDB]  = cur_bank;
  assign map_bank[M_WR]   = cur_bank;
  assign map_bank[M_LINK] = cur_bank;
  assign map_bank[M_EXC]  = exc_bank;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rf_index_map #(.PW(PW)) u_map (
      .idx_i(map_idx[m]), .bank_i(map_bank[m]), .phys_o(map_phys[m])
    );
  end

  // program counter stays word aligned
  assign wr_data_al = (wr_idx_i == 4'd15) ? {wr_data_i[DW-1:2], 2'b00} : wr_data_i;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_gpr
    logic hit_exc, hit_link, hit_wr;
    assign hit_exc  = exc_take && map_phys[M_EXC] == PW'(p);
    assign hit_link = !exc_take && link_en_i && map_phys[M_LINK] == PW'(p);
    assign hit_wr   = !exc_take && wr_en_i && map_phys[M_WR] == PW'(p);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       gpr_q[p] <= '0;
      else if (hit_exc)  gpr_q[p] <= exc_ret_addr_i;
      else if (hit_link) gpr_q[p] <= link_addr_i;
      else if (hit_wr)   gpr_q[p] <= wr_data_al;
    end
  end

  assign rd_a_data_o = gpr_q[map_phys[M_RDA]];
  assign rd_b_data_o = gpr_q[map_phys[M_RDB]];

  rf_status #(.DW(DW)) u_status (
    .clk_i, .rst_ni,
    .cur_bank_i(cur_bank), .cur_is_exc_i(cur_is_exc),
    .exc_take_i(exc_take), .exc_mode_i(exc_mode_i), .exc_bank_i(exc_bank),
    .cpsr_we_i(cpsr_wr_en_i), .cpsr_wd_i(cpsr_wr_data_i),
    .spsr_we_i(spsr_wr_en_i), .spsr_wd_i(spsr_wr_data_i),
    .cpsr_o(cpsr_o), .spsr_o(spsr_o)
  );

  logic unused_legal;
  assign unused_legal = cur_legal ^ exc_legal;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_regfile_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    rd_a_idx_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic [3:0]    rd_b_idx_i,
  input logic [DW-1:0] rd_b_data_o,
  input logic          cpsr_wr_en_i,
  input logic [DW-1:0] cpsr_wr_data_i,
  input logic [DW-1:0] cpsr_o,
  input logic [DW-1:0] spsr_o,
  input logic          exc_en_i,
  input logic [4:0]    exc_mode_i
);
  // R6
  pc_align_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == 4'd15 |-> rd_a_data_o[1:0] == 2'b00);
  // R6
  pc_align_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == 4'd15 |-> rd_b_data_o[1:0] == 2'b00);
  // R7
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(cpsr_o[4:0]));
  // R7
  bad_mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_wr_en_i && !exc_en_i && !mode_legal(cpsr_wr_data_i[4:0])
    |=> cpsr_o[4:0] == $past(cpsr_o[4:0]));
  // R8
  spsr_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_is_exc(cpsr_o[4:0]) |-> spsr_o == cpsr_o);
  // R9
  exc_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_en_i && mode_is_exc(exc_mode_i)
    |=> cpsr_o == {$past(cpsr_o[DW-1:5]), $past(exc_mode_i)} && spsr_o == $past(cpsr_o));
  // R10
  exc_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_en_i && !mode_is_exc(exc_mode_i) && !cpsr_wr_en_i |=> $stable(cpsr_o));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
  .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
  .cpsr_wr_en_i(cpsr_wr_en_i), .cpsr_wr_data_i(cpsr_wr_data_i),
  .cpsr_o(cpsr_o), .spsr_o(spsr_o),
  .exc_en_i(exc_en_i), .exc_mode_i(exc_mode_i)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, cpsr, spsr;
  logic        wr_en = 0, link_en = 0, cpsr_we = 0, spsr_we = 0, exc_en = 0;
  logic [31:0] wr_data = '0, link_addr = '0, cpsr_wd = '0, spsr_wd = '0, exc_ret = '0;
  logic [4:0]  exc_mode = 5'b10000;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // behavioural model: storage keyed by (owner mode code * 16 + index)
  logic [31:0] m_gpr [int];
  logic [31:0] m_saved [int];
  logic [31:0] m_cpsr;

  always #4 clk = ~clk;

  banked_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .link_en_i(link_en), .link_addr_i(link_addr),
    .cpsr_wr_en_i(cpsr_we), .cpsr_wr_data_i(cpsr_wd), .cpsr_o(cpsr),
    .spsr_wr_en_i(spsr_we), .spsr_wr_data_i(spsr_wd), .spsr_o(spsr),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .exc_ret_addr_i(exc_ret)
  );

  function automatic bit is_exc(logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h16 || m == 5'h17 || m == 5'h1b;
  endfunction
  function automatic bit legal(logic [4:0] m);
    return is_exc(m) || m == 5'h10 || m == 5'h1f;
  endfunction
  function automatic int key(logic [4:0] m, logic [3:0] i);
    if (i < 8 || i == 15) return int'(i);
    if (m == 5'h11) return 17 * 16 + int'(i);
    if (i >= 13 && is_exc(m)) return int'(m) * 16 + int'(i);
    return int'(i);
  endfunction
  function automatic logic [31:0] m_read(logic [4:0] m, logic [3:0] i);
    int k = key(m, i);
    return m_gpr.exists(k) ? m_gpr[k] : 32'h0;
  endfunction
  function automatic logic [31:0] m_spsr();
    if (!is_exc(m_cpsr[4:0])) return m_cpsr;
    return m_saved.exists(int'(m_cpsr[4:0])) ? m_saved[int'(m_cpsr[4:0])] : 32'h0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; link_en = 0; cpsr_we = 0; spsr_we = 0; exc_en = 0;
  endtask

  // compare outputs for current inputs, advance model, cross one edge
  task automatic step();
    logic [4:0] cur;
    #1;
    chk("rd_a", rd_a_data, m_read(m_cpsr[4:0], rd_a_idx));
    chk("rd_b", rd_b_data, m_read(m_cpsr[4:0], rd_b_idx));
    chk("cpsr", cpsr, m_cpsr);
    chk("spsr", spsr, m_spsr());
    cur = m_cpsr[4:0];
    if (exc_en && is_exc(exc_mode)) begin
      m_saved[int'(exc_mode)] = m_cpsr;
      m_cpsr = {m_cpsr[31:5], exc_mode};
      m_gpr[key(exc_mode, 4'd14)] = exc_ret;
    end else begin
      if (wr_en) m_gpr[key(cur, wr_idx)] = (wr_idx == 15) ? {wr_data[31:2], 2'b00} : wr_data;
      if (link_en) m_gpr[key(cur, 4'd14)] = link_addr;
      if (cpsr_we) m_cpsr = legal(cpsr_wd[4:0]) ? cpsr_wd : {cpsr_wd[31:5], cur};
      if (spsr_we && is_exc(cur)) m_saved[int'(cur)] = spsr_wd;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic set_mode(logic [4:0] m);
    cpsr_we = 1; cpsr_wd = {m_cpsr[31:5], m};
    step();
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d;
    step();
  endtask

  task automatic rd_expect(logic [3:0] i, logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i;
    #1;
    chk("literal", rd_a_data, exp);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_cpsr = 32'h13;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1";
    #1 chk("reset cpsr", cpsr, 32'h0000_0013);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      step();
    end

    tag = "R2";
    wr(4'd3, 32'hCAFE_0003);
    rd_expect(4'd3, 32'hCAFE_0003);
    set_mode(5'h11);
    rd_expect(4'd3, 32'hCAFE_0003);

    tag = "R3";
    set_mode(5'h10);
    wr(4'd13, 32'h0000_AAA0);
    set_mode(5'h1f);
    rd_expect(4'd13, 32'h0000_AAA0);
    set_mode(5'h12);
    rd_expect(4'd13, 32'h0);
    wr(4'd13, 32'h1212_0000);
    set_mode(5'h17);
    rd_expect(4'd13, 32'h0);
    set_mode(5'h10);
    rd_expect(4'd13, 32'h0000_AAA0);

    tag = "R4";
    wr(4'd9, 32'h0909_0909);
    set_mode(5'h11);
    rd_expect(4'd9, 32'h0);
    wr(4'd9, 32'hF1F1_0009);
    set_mode(5'h13);
    rd_expect(4'd9, 32'h0909_0909);

    tag = "R5";
    link_en = 1; link_addr = 32'h0000_4004;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'hDEAD_0000;
    step();
    rd_expect(4'd14, 32'h0000_4004);

    tag = "R6";
    wr(4'd15, 32'h0000_1237);
    rd_expect(4'd15, 32'h0000_1234);

    tag = "R7";
    cpsr_we = 1; cpsr_wd = 32'hF000_0005;
    step();
    #1 chk("mode kept", {27'h0, cpsr[4:0]}, 32'h13);
    chk("upper written", {cpsr[31:5], 5'h0}, 32'hF000_0000);
    set_mode(5'h16);

    tag = "R8";
    spsr_we = 1; spsr_wd = 32'h5555_0010;
    step();
    set_mode(5'h10);
    spsr_we = 1; spsr_wd = 32'h7777_7777;
    step();
    #1 chk("spsr alias", spsr, cpsr);
    set_mode(5'h16);
    #1 chk("spsr mon", spsr, 32'h5555_0010);

    tag = "R9";
    exc_en = 1; exc_mode = 5'h12; exc_ret = 32'h0000_0818;
    wr_en = 1; wr_idx = 4'd2; wr_data = 32'hBAD0_0002;
    cpsr_we = 1; cpsr_wd = 32'h0000_001F;
    step();
    rd_expect(4'd14, 32'h0000_0818);
    rd_expect(4'd2, 32'h0);

    tag = "R10";
    exc_en = 1; exc_mode = 5'h1f; exc_ret = 32'h1111_1111;
    wr_en = 1; wr_idx = 4'd4; wr_data = 32'h0000_0404;
    step();
    rd_expect(4'd4, 32'h0000_0404);
    exc_en = 1; exc_mode = 5'h05;
    step();

    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] modes [10] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h16,
                                 5'h17, 5'h1b, 5'h1f, 5'h00, 5'h14};
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
      link_en = ($urandom % 8) == 0; link_addr = $urandom;
      cpsr_we = ($urandom % 6) == 0;
      cpsr_wd = {$urandom, 5'h0} | 32'(modes[$urandom % 10]);
      spsr_we = ($urandom % 5) == 0; spsr_wd = $urandom;
      exc_en = ($urandom % 9) == 0; exc_mode = modes[$urandom % 10]; exc_ret = $urandom;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule